// File: doc/BRIEF.md
# LUT-Based Distributed RAM

This block is a small bit-wide storage array that doubles as a logic look-up table. Each leaf unit holds eight one-bit cells. Three address lines steer a binary multiplexer tree that picks one stored bit and presents it at the output, the same way a truth table is evaluated for a three-input function. When write enable is high, an address decoder raises a strobe for exactly one cell, and that cell alone captures the data-in bit at the clock edge.

The top level cascades several leaf units into a deeper memory. The upper address bits do two things. They steer write enable to a single unit, and they select which unit's output reaches the pin. With the default parameters this gives a 16x1 memory. An initial-contents load port replaces every cell in one clock edge, so the whole array can be configured as a logic function. Clocked flops stand in for the storage latches.

All pins are plain control and data pins. The block carries no stream traffic, so there is no valid/ready handshake and no back-pressure.

Top module: `lutram_cascade`

## Requirements
- R1: While rst_n is low, and after it is released, every cell reads 0 until it is written or loaded.
- R2: The read path is combinational. In the same cycle, dout equals the stored bit whose index is addr.
- R3: When we is high at a rising clock edge, the cell at addr takes din. dout shows the new value only after that edge, and the old value before it.
- R4: A write changes only the addressed cell. Every other cell keeps its value.
- R5: When we and init_load are both low, no cell changes, whatever the values on din and addr. The block then acts as a fixed function of addr, with output init_bits[addr] after a load.
- R6: When init_load is high at a rising edge, every cell i takes init_bits[i], and bit i stands for address i. init_load takes priority over a write in the same cycle.
- R7: The upper CASC_W address bits pick a unit. Unit k holds addresses k*8 to k*8+7. A write reaches only the selected unit, and dout comes from that unit.
- R8: Within a unit, at most one cell write strobe is active in any cycle, and none is active while the unit's write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all cells update on its rising edge |
| rst_n | input | 1 | Active-low reset; clears every cell |
| init_load | input | 1 | Load all cells from init_bits at the next edge |
| init_bits | input | 2**(LEAF_AW+CASC_W) | Initial contents; bit i is the value for address i |
| we | input | 1 | Write enable for a single-cell write |
| addr | input | LEAF_AW+CASC_W | Read and write address, and the logic-function inputs |
| din | input | 1 | Data bit to write |
| dout | output | 1 | Bit stored at addr, read combinationally |

## Verification
The bench builds the block with LEAF_AW=3 and CASC_W=1, which gives two eight-cell units behind one unit-select bit. This puts the boundary between unit 0 and unit 1, at addresses 7 and 8, within reach. It also lets the bench show that a write in one unit leaves the other unit untouched. Every one of the sixteen truth-table positions is read back after loads, after writes and after idle cycles in which din and addr are toggled.

// File: rtl/lutram_pkg.sv
package lutram_pkg;
  // number of cells addressed by an address field of the given width
  function automatic int unsigned cells_for(input int unsigned aw);
    return 32'd1 << aw;
  endfunction
endpackage

// File: rtl/lutram_wdec.sv
module lutram_wdec #(
  parameter int unsigned AW = 3,
  localparam int unsigned N = lutram_pkg::cells_for(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  strobe
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign strobe[i] = we && (addr == AW'(i));
  end

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));
  a_r8_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !we |-> (strobe == '0));
endmodule

// File: rtl/lutram_mux.sv
module lutram_mux #(
  parameter int unsigned AW = 3,
  localparam int unsigned N = lutram_pkg::cells_for(AW)
) (
  input  logic [N-1:0]  bits,
  input  logic [AW-1:0] sel,
  output logic          q
);
  // heap layout: node 1 is the root, leaves sit at N..2N-1
  logic [2*N-1:1] node;

  for (genvar j = 0; j < N; j++) begin : g_leaf
    assign node[N+j] = bits[j];
  end

  for (genvar k = 1; k < N; k++) begin : g_node
    localparam int unsigned DEPTH = $clog2(k + 1) - 1;
    assign node[k] = sel[AW-1-DEPTH] ? node[2*k+1] : node[2*k];
  end

  assign q = node[1];

  always_comb begin
    a_r2_tree_matches_index: assert (q === bits[sel] || $isunknown(sel));
  end
endmodule

// File: rtl/lutram_cell.sv
module lutram_cell #(
  parameter int unsigned AW = 3,
  localparam int unsigned N = lutram_pkg::cells_for(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_load,
  input  logic [N-1:0]  init_bits,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic          dout
);
  logic [N-1:0] mem;
  logic [N-1:0] strobe;

  lutram_wdec #(.AW(AW)) u_wdec (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .strobe(strobe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (init_load) begin
      mem <= init_bits;
    end else begin
      for (int i = 0; i < int'(N); i++) begin
        if (strobe[i]) mem[i] <= din;
      end
    end
  end

  lutram_mux #(.AW(AW)) u_mux (.bits(mem), .sel(addr), .q(dout));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !init_load) |=> (mem[$past(addr)] == $past(din)));
  a_r4_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !init_load) |=> (((mem ^ $past(mem)) & ~$past(strobe)) == '0));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !init_load) |=> $stable(mem));
  a_r6_load_all: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |=> (mem == $past(init_bits)));
endmodule

// File: rtl/lutram_cascade.sv
module lutram_cascade #(
  parameter int unsigned LEAF_AW = 3,
  parameter int unsigned CASC_W  = 1,
  localparam int unsigned AW    = LEAF_AW + CASC_W,
  localparam int unsigned LEAF  = lutram_pkg::cells_for(LEAF_AW),
  localparam int unsigned UNITS = lutram_pkg::cells_for(CASC_W),
  localparam int unsigned DEPTH = LEAF * UNITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_load,
  input  logic [DEPTH-1:0] init_bits,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic             din,
  output logic             dout
);
  if (CASC_W == 0) begin : g_single
    lutram_cell #(.AW(LEAF_AW)) u_cell (
      .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_bits(init_bits),
      .we(we), .addr(addr), .din(din), .dout(dout)
    );
  end else begin : g_multi
    logic [CASC_W-1:0] unit_sel;
    logic [UNITS-1:0]  unit_we;
    logic [UNITS-1:0]  unit_dout;

    assign unit_sel = addr[AW-1:LEAF_AW];

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
      assign unit_we[u] = we && (unit_sel == CASC_W'(u));
      lutram_cell #(.AW(LEAF_AW)) u_cell (
        .clk(clk), .rst_n(rst_n), .init_load(init_load),
        .init_bits(init_bits[u*LEAF +: LEAF]),
        .we(unit_we[u]), .addr(addr[LEAF_AW-1:0]), .din(din),
        .dout(unit_dout[u])
      );
    end

    assign dout = unit_dout[unit_sel];

    a_r7_one_unit_written: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(unit_we));
    a_r7_we_reaches_unit: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> ($countones(unit_we) == 1));
  end
endmodule

// File: tb/lutram_cascade_tb_top.sv
`timescale 1ns/100ps
module lutram_cascade_tb_top;
  localparam int DEPTH = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             init_load = 1'b0;
  logic [DEPTH-1:0] init_bits = '0;
  logic             we = 1'b0;
  logic [3:0]       addr = '0;
  logic             din = 1'b0;
  logic             dout;

  logic [DEPTH-1:0] model = '0;
  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  lutram_cascade #(.LEAF_AW(3), .CASC_W(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_bits(init_bits),
    .we(we), .addr(addr), .din(din), .dout(dout)
  );

  task automatic chk(input string req, input int a, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d actual=%b expected=%b", req, a, got, exp);
    end
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      addr = 4'(a);
      #0.1;
      chk(req, a, dout, model[a]);
    end
  endtask

  task automatic do_write(input int a, input logic d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); din = d;
    #0.1;
    chk("R3 old value before edge", a, dout, model[a]);
    @(negedge clk);
    we = 1'b0;
    model[a] = d;
    #0.1;
    chk("R3 new value after edge", a, dout, d);
  endtask

  task automatic do_load(input logic [DEPTH-1:0] pat);
    @(negedge clk);
    init_bits = pat; init_load = 1'b1;
    @(negedge clk);
    init_load = 1'b0;
    model = pat;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model = '0;
    read_all("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1 after reset");
  endtask

  task automatic t_lut_function();
    do_load(16'hA5C3);
    read_all("R6 load and R2 read");
    do_load(16'h3C96);
    read_all("R5 logic function");
  endtask

  task automatic t_writes();
    do_write(3, ~model[3]);
    read_all("R4 after write 3");
    do_write(12, ~model[12]);
    read_all("R4 after write 12");
    do_write(0, 1'b1);
    do_write(15, ~model[15]);
    read_all("R4 after corner writes");
  endtask

  task automatic t_idle();
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      we = 1'b0; din = c[0]; addr = 4'(c * 5);
    end
    @(negedge clk);
    read_all("R5 idle ignored");
  endtask

  task automatic t_load_priority();
    @(negedge clk);
    init_bits = 16'h0F0F; init_load = 1'b1;
    we = 1'b1; addr = 4'd2; din = 1'b0;
    @(negedge clk);
    init_load = 1'b0; we = 1'b0;
    model = 16'h0F0F;
    read_all("R6 load wins over write");
  endtask

  task automatic t_cascade();
    do_load(16'h0000);
    do_write(7, 1'b1);
    read_all("R7 unit0 top cell");
    do_write(8, 1'b1);
    read_all("R7 unit1 bottom cell");
    do_write(7, 1'b0);
    read_all("R7 unit1 untouched");
  endtask

  initial begin
    t_reset();
    t_lut_function();
    t_writes();
    t_idle();
    t_load_priority();
    t_cascade();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule